// File: doc/BRIEF.md
# Grouped Wake Interrupt Aggregator

This block forms a 64-bit top-level interrupt view that a wake-up controller watches while the system sleeps. A handful of direct request lines each own one top-level bit. Up to 128 further lines are first gated one by one by a mux-enable bank, and then folded eight at a time onto a run of top-level bits. Every top-level bit is gated by its own enable bit, and the result is readable as pending status. A single `wake` output rises whenever any pending bit is set.

All request inputs pass through a clocked synchroniser before any gating. A simple 32-bit register port with a byte address and a write strobe exposes the two enable words, the four mux-enable words and the two read-only pending words. The `VARIANT` parameter selects between two layouts. Layout 0 has 18 direct lines, groups starting at top-level bit 19, 13 groups and a sparse validity mask on the muxed lines. Layout 1 has 20 direct lines, groups starting at bit 21, 16 groups and every muxed line valid.

Top module: `wake_aggregator`

## Requirements
- R1: After reset, every enable and mux-enable word reads 0 and `wake` is low.
- R2: Direct input bit k drives top-level bit k+1. Top-level bit 0 has no source and always reads 0 as pending.
- R3: Muxed line m, when its mux-enable bit m is set, drives top-level bit F + floor(m/8). F is 19 in layout 0 and 21 in layout 1. The eight lines of a group are OR-combined.
- R4: A muxed line whose mux-enable bit is clear contributes nothing to its group bit.
- R5: A pending bit reads as its top-level source ANDed with the matching top-level enable bit.
- R6: In layout 0, only these muxed lines are valid: word 0 mask FFFFFFFF, word 1 mask FFF80000, word 2 mask FFFFFFFF and word 3 mask 0000000F (word k covers lines 32k to 32k+31). Mux-enable bits of invalid lines ignore writes and read 0. In layout 1, all 128 lines are valid.
- R7: `wake` is high exactly when at least one of the 64 pending bits is set.
- R8: Pending words are read-only. A write to offset 0x10 or 0x14 changes no register.
- R9: Reads of an unmapped or misaligned byte offset return 0, and writes to such an offset change no register.
- R10: A change on a request input shows in pending status after exactly `SYNC_STAGES` rising clock edges (2 by default), and not after one.
- R11: Register map, byte offsets. Pending bits 31..0 are at 0x10 and bits 63..32 at 0x14. Enable bits 31..0 are at 0x40 and bits 63..32 at 0x44. Mux-enable word k (lines 32k+31..32k) is at 0xC0+4k, for k = 0..3. Bit n of a word is the bit of index n within its range.
- R12: In layout 1, direct input bit 19 drives top-level bit 20, and muxed line 127 drives top-level bit 36.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| direct_irq | input | NUM_DIRECT (18 or 20) | Direct request lines, bit k drives top-level bit k+1 |
| mux_irq | input | 128 | Muxed request lines |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| wake | output | 1 | High while any pending bit is set |

## Verification
The grouping path is driven with single muxed lines at both ends of a group (lines 0 and 7) and with the first line of the next group (line 8). These separate a correct floor(m/8) mapping from an off-by-one group index. Lines placed on either side of the layout-0 validity boundaries (40 against 51, 99 against 104) tell the stored mask apart from a plain all-ones bank. Direct lines at the lowest and highest positions, combined with partial enable patterns, check the bit-k-to-k+1 offset separately from the enable gating. The second layout instance confirms that the group base and group count follow the parameter.

// File: rtl/wake_agg_pkg.sv
package wake_agg_pkg;

  localparam int TOP_W   = 64;
  localparam int REG_W   = 32;
  localparam int MUX_W   = 128;
  localparam int GRP_SZ  = 8;
  localparam int ADDR_W  = 8;
  localparam int MUX_WORDS = MUX_W / REG_W;
  localparam int TOP_WORDS = TOP_W / REG_W;

  // word indices (byte offset / 4)
  localparam logic [5:0] WIDX_PEND = 6'h04;
  localparam logic [5:0] WIDX_EN   = 6'h10;
  localparam logic [5:0] WIDX_MUX  = 6'h30;

  typedef enum logic [1:0] {SEL_NONE, SEL_PEND, SEL_EN, SEL_MUX} sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [1:0] idx;
  } dec_t;

  function automatic int first_mux_bit(input int variant);
    return (variant == 1) ? 21 : 19;
  endfunction

  function automatic int num_groups(input int variant);
    return (variant == 1) ? 16 : 13;
  endfunction

  function automatic int num_direct(input int variant);
    return first_mux_bit(variant) - 1;
  endfunction

  // Per-line validity of the muxed inputs
  function automatic logic [MUX_W-1:0] mux_valid_mask(input int variant);
    logic [MUX_W-1:0] m;
    if (variant == 1) begin
      m = '1;
    end else begin
      m = {32'h0000000F, 32'hFFFFFFFF, 32'hFFF80000, 32'hFFFFFFFF};
    end
    return m;
  endfunction

  function automatic int group_of(input int line);
    return line / GRP_SZ;
  endfunction

  // Address decode: aligned word offsets only
  function automatic dec_t decode(input logic [ADDR_W-1:0] addr);
    dec_t d;
    logic [5:0] w;
    d.sel = SEL_NONE;
    d.idx = 2'd0;
    w = addr[ADDR_W-1:2];
    if (addr[1:0] == 2'b00) begin
      if (w[5:1] == WIDX_PEND[5:1]) begin
        d.sel = SEL_PEND;
        d.idx = {1'b0, w[0]};
      end else if (w[5:1] == WIDX_EN[5:1]) begin
        d.sel = SEL_EN;
        d.idx = {1'b0, w[0]};
      end else if (w[5:2] == WIDX_MUX[5:2]) begin
        d.sel = SEL_MUX;
        d.idx = w[1:0];
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wake_mux_bank.sv
module wake_mux_bank
  import wake_agg_pkg::*;
#(
  parameter int VARIANT = 0,
  localparam int NG = num_groups(VARIANT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_idx,
  input  logic [REG_W-1:0] wdata,
  input  logic [MUX_W-1:0] lines,
  output logic [MUX_W-1:0] mux_en,
  output logic [NG-1:0]    grp
);

  localparam logic [MUX_W-1:0] VALID = mux_valid_mask(VARIANT);

  logic [MUX_W-1:0] gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_en <= '0;
    end else if (wr_en) begin
      mux_en[wr_idx*REG_W +: REG_W] <= wdata & VALID[wr_idx*REG_W +: REG_W];
    end
  end

  assign gated = lines & mux_en;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp[g] = |gated[g*GRP_SZ +: GRP_SZ];

    // R4: a group bit needs at least one enabled line in its group
    p_grp_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grp[g] |-> (|mux_en[g*GRP_SZ +: GRP_SZ]));
  end

  // R6: invalid lines never hold an enable bit
  p_mux_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_en & ~VALID) == '0);

  // R9: bank only changes on its own write strobe
  p_mux_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mux_en));

endmodule

// File: rtl/wake_top_bank.sv
module wake_top_bank
  import wake_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_idx,
  input  logic [REG_W-1:0] wdata,
  input  logic [TOP_W-1:0] src,
  output logic [TOP_W-1:0] en,
  output logic [TOP_W-1:0] pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
    end else if (wr_en) begin
      en[wr_idx*REG_W +: REG_W] <= wdata;
    end
  end

  assign pend = src & en;

  // R8: enables only change on their own write strobe
  p_en_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en));

endmodule

// File: rtl/wake_aggregator.sv
module wake_aggregator
  import wake_agg_pkg::*;
#(
  parameter int VARIANT     = 0,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_DIRECT = num_direct(VARIANT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DIRECT-1:0] direct_irq,
  input  logic [MUX_W-1:0]      mux_irq,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  wake
);

  localparam int FIRST = first_mux_bit(VARIANT);
  localparam int NG    = num_groups(VARIANT);
  localparam int IN_W  = NUM_DIRECT + MUX_W;

  logic [IN_W-1:0]       in_sync;
  logic [NUM_DIRECT-1:0] dir_s;
  logic [MUX_W-1:0]      mux_s;
  logic [MUX_W-1:0]      mux_en;
  logic [NG-1:0]         grp;
  logic [TOP_W-1:0]      src;
  logic [TOP_W-1:0]      en;
  logic [TOP_W-1:0]      pend;
  dec_t                  dec;

  // named events for assertions
  logic ev_wr_en, ev_wr_mux, ev_wr_pend, ev_wr_unmapped;

  wake_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mux_irq, direct_irq}),
    .q     (in_sync)
  );

  assign dir_s = in_sync[NUM_DIRECT-1:0];
  assign mux_s = in_sync[IN_W-1:NUM_DIRECT];

  assign dec            = decode(reg_addr);
  assign ev_wr_en       = reg_wr && (dec.sel == SEL_EN);
  assign ev_wr_mux      = reg_wr && (dec.sel == SEL_MUX);
  assign ev_wr_pend     = reg_wr && (dec.sel == SEL_PEND);
  assign ev_wr_unmapped = reg_wr && (dec.sel == SEL_NONE);

  wake_mux_bank #(.VARIANT(VARIANT)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ev_wr_mux),
    .wr_idx (dec.idx),
    .wdata  (reg_wdata),
    .lines  (mux_s),
    .mux_en (mux_en),
    .grp    (grp)
  );

  always_comb begin
    src = '0;
    src[NUM_DIRECT:1] = dir_s;
    src[FIRST +: NG]  = grp;
  end

  wake_top_bank u_top (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ev_wr_en),
    .wr_idx (dec.idx[0]),
    .wdata  (reg_wdata),
    .src    (src),
    .en     (en),
    .pend   (pend)
  );

  always_comb begin
    unique case (dec.sel)
      SEL_PEND: reg_rdata = pend[dec.idx[0]*REG_W +: REG_W];
      SEL_EN:   reg_rdata = en[dec.idx[0]*REG_W +: REG_W];
      SEL_MUX:  reg_rdata = mux_en[dec.idx*REG_W +: REG_W];
      default:  reg_rdata = '0;
    endcase
  end

  assign wake = |pend;

  // R1: registers come out of reset cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en == '0) && (mux_en == '0));

  // R7: wake can only be high with some enable set
  p_wake_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|en));

  // R8: pending writes change no register
  p_ro_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_pend |=> $stable(en) && $stable(mux_en));

  // R9: unmapped writes change no register
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_unmapped |=> $stable(en) && $stable(mux_en));

  // R9: unmapped reads return zero
  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.sel == SEL_NONE) |-> (reg_rdata == '0));

endmodule

// File: tb/test_wake_aggregator.sv
module test_wake_aggregator;

  typedef struct packed {
    logic [19:0] dir;
    logic        mux_on;
    logic [6:0]  line;
    logic [31:0] en_lo;
    logic [31:0] pend_lo;
  } vec_t;

  // Layout 0: direct k -> bit k+1, line m -> bit 19 + m/8
  localparam vec_t VEC [13] = '{
    '{20'h00000, 1'b0, 7'd0,   32'hFFFFFFFF, 32'h00000000},
    '{20'h00001, 1'b0, 7'd0,   32'hFFFFFFFF, 32'h00000002},
    '{20'h20000, 1'b0, 7'd0,   32'hFFFFFFFF, 32'h00040000},
    '{20'h00000, 1'b1, 7'd0,   32'hFFFFFFFF, 32'h00080000},
    '{20'h00000, 1'b1, 7'd7,   32'hFFFFFFFF, 32'h00080000},
    '{20'h00000, 1'b1, 7'd8,   32'hFFFFFFFF, 32'h00100000},
    '{20'h00000, 1'b1, 7'd99,  32'hFFFFFFFF, 32'h80000000},
    '{20'h00000, 1'b1, 7'd40,  32'hFFFFFFFF, 32'h00000000},
    '{20'h00000, 1'b1, 7'd51,  32'hFFFFFFFF, 32'h02000000},
    '{20'h00001, 1'b0, 7'd0,   32'h00000000, 32'h00000000},
    '{20'h3FFFF, 1'b0, 7'd0,   32'h00000006, 32'h00000006},
    '{20'h00000, 1'b1, 7'd63,  32'h04000000, 32'h04000000},
    '{20'h00000, 1'b1, 7'd104, 32'hFFFFFFFF, 32'h00000000}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [17:0]  dir0 = '0;
  logic [19:0]  dir1 = '0;
  logic [127:0] mux_irq = '0;
  logic [7:0]   reg_addr = '0;
  logic         wr0 = 1'b0;
  logic         wr1 = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  rdata0, rdata1;
  logic         wake0, wake1;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wake_aggregator #(.VARIANT(0)) i_wake_aggregator (
    .clk(clk), .rst_n(rst_n), .direct_irq(dir0), .mux_irq(mux_irq),
    .reg_addr(reg_addr), .reg_wr(wr0), .reg_wdata(reg_wdata),
    .reg_rdata(rdata0), .wake(wake0)
  );

  wake_aggregator #(.VARIANT(1)) i_wake_aggregator_wide (
    .clk(clk), .rst_n(rst_n), .direct_irq(dir1), .mux_irq(mux_irq),
    .reg_addr(reg_addr), .reg_wr(wr1), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .wake(wake1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit wide, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d;
    if (wide) wr1 = 1'b1; else wr0 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input bit wide, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = wide ? rdata1 : rdata0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 8'h40, d); check("R1 en lo", d, 32'h0);
    rd(0, 8'h44, d); check("R1 en hi", d, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(0, 8'hC0 + 8'(4*k), d); check("R1 mux word", d, 32'h0);
    end
    check("R1 wake", {31'b0, wake0}, 32'h0);

    // R6 / R11 valid mask readback
    for (int k = 0; k < 4; k++) wr(0, 8'hC0 + 8'(4*k), 32'hFFFFFFFF);
    rd(0, 8'hC0, d); check("R6 word0", d, 32'hFFFFFFFF);
    rd(0, 8'hC4, d); check("R6 word1", d, 32'hFFF80000);
    rd(0, 8'hC8, d); check("R6 word2", d, 32'hFFFFFFFF);
    rd(0, 8'hCC, d); check("R6 word3", d, 32'h0000000F);

    // Table: R2 R3 R5 R6 R7 R11
    wr(0, 8'h44, 32'hFFFFFFFF);
    for (int i = 0; i < 13; i++) begin
      wr(0, 8'h40, VEC[i].en_lo);
      dir0 = VEC[i].dir[17:0];
      mux_irq = '0;
      if (VEC[i].mux_on) mux_irq[VEC[i].line] = 1'b1;
      settle();
      rd(0, 8'h10, d); check("R2/R3/R5 pend lo", d, VEC[i].pend_lo);
      rd(0, 8'h14, d); check("R11 pend hi", d, 32'h0);
      check("R7 wake", {31'b0, wake0}, {31'b0, VEC[i].pend_lo != 0});
    end
    dir0 = '0; mux_irq = '0;
    wr(0, 8'h40, 32'hFFFFFFFF);

    // R4: line 3 with its mux-enable cleared
    wr(0, 8'hC0, 32'hFFFFFFF7);
    mux_irq[3] = 1'b1;
    settle();
    rd(0, 8'h10, d); check("R4 disabled line", d, 32'h0);
    check("R7 wake low", {31'b0, wake0}, 32'h0);
    wr(0, 8'hC0, 32'hFFFFFFFF);
    settle();
    rd(0, 8'h10, d); check("R4 re-enabled line", d, 32'h00080000);

    // R3 OR within a group
    mux_irq = '0; mux_irq[0] = 1'b1; mux_irq[5] = 1'b1;
    settle();
    rd(0, 8'h10, d); check("R3 group or", d, 32'h00080000);
    mux_irq = '0;

    // R8 pending read-only
    wr(0, 8'h10, 32'hFFFFFFFF);
    wr(0, 8'h14, 32'hFFFFFFFF);
    rd(0, 8'h40, d); check("R8 en lo kept", d, 32'hFFFFFFFF);
    rd(0, 8'hC4, d); check("R8 mux kept", d, 32'hFFF80000);
    settle();
    rd(0, 8'h10, d); check("R8 pend zero", d, 32'h0);

    // R9 unmapped
    wr(0, 8'h44, 32'h0);
    wr(0, 8'h48, 32'hFFFFFFFF);
    wr(0, 8'h45, 32'hFFFFFFFF);
    wr(0, 8'hC0 + 8'd16, 32'h0);
    rd(0, 8'h44, d); check("R9 en hi kept", d, 32'h0);
    rd(0, 8'hC0, d); check("R9 mux kept", d, 32'hFFFFFFFF);
    rd(0, 8'h48, d); check("R9 read zero", d, 32'h0);
    rd(0, 8'h41, d); check("R9 misaligned read", d, 32'h0);

    // R2 bit 0 has no source
    dir0 = '1;
    settle();
    rd(0, 8'h10, d); check("R2 bit0 zero", {31'b0, d[0]}, 32'h0);
    dir0 = '0;
    settle();

    // R10 latency
    @(negedge clk);
    dir0[0] = 1'b1;
    reg_addr = 8'h10;
    @(negedge clk); #1;
    check("R10 after one edge", rdata0, 32'h0);
    @(negedge clk); #1;
    check("R10 after two edges", rdata0, 32'h2);
    dir0 = '0;

    // R12 layout 1
    wr(1, 8'hC4, 32'hFFFFFFFF);
    rd(1, 8'hC4, d); check("R6 wide all valid", d, 32'hFFFFFFFF);
    wr(1, 8'hCC, 32'hFFFFFFFF);
    wr(1, 8'h40, 32'hFFFFFFFF);
    wr(1, 8'h44, 32'hFFFFFFFF);
    mux_irq = '0; mux_irq[127] = 1'b1;
    dir1 = '0; dir1[19] = 1'b1;
    settle();
    rd(1, 8'h14, d); check("R12 line127 bit36", d, 32'h00000010);
    rd(1, 8'h10, d); check("R12 direct19 bit20", d, 32'h00100000);
    check("R12 wake", {31'b0, wake1}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule